// File: doc/BRIEF.md
# Synchronous Memory-Card Activation Sequencer

This block brings up the contacts of a synchronous-type memory card. A host writes small configuration registers through a plain write port. Once the start condition holds, the block powers the card and gives the card clock a single high pulse while the supply ramps. It holds C4 low until a fixed delay after that pulse, then releases C4 and hands the card clock to an external clock generator. After the supply reports good, it pulls up the I/O line, drives C8 and optionally links the card I/O to the host. It finishes by raising a completion flag and pulling its active-low interrupt.

All delays count a one-cycle microsecond tick supplied from outside. Each delay is a parameter whose default is the typical figure. If power-good does not arrive within a timeout after the C4 release, the block drops every card line, returns to idle and raises an error flag.

Register map (write-only, 8-bit data). Activation control is at address `ACT_ADDR` (default 0): bit 0 start, bit 2 reset level, bit 4 C8 level, bit 6 activation type, bit 7 card type. Supply configuration is at `SUP_ADDR` (default 1): bits [7:6] supply level, bit 5 I/O link enable. Clock configuration is at `CLK_ADDR` (default 2): all 8 bits pass to the clock generator. Status is at `STAT_ADDR` (default 3), write 1 to clear: bit 1 done, bit 0 error.

Top module: `card_sync_activate`

## Requirements
- R1: A sequence starts only when start (bit 0), activation type (bit 6) and card type (bit 7) of the activation register are all 1. With any of the three at 0, no card line moves.
- R2: After reset and while idle, vccEn, vccSel, cardRst, cardClk, c4, c8, ioPullUp and ioLink are all 0, intN is 1 and both status flags are 0.
- R3: vccEn goes high when the sequence starts. While vccEn is high, vccSel equals supply register bits [7:6]; otherwise vccSel is 0.
- R4: From the supply turning on until the clock pulse, exactly `VCC_TO_CLK_US` ticks (default 20) pass with cardClk and c4 low.
- R5: Exactly one cardClk high pulse is produced before the C4 release, and it lasts `CLK_HI_US` ticks (default 9).
- R6: c4 stays low for `CLK_TO_C4_US` ticks (default 18) after the pulse ends, then goes high.
- R7: Before the C4 release, extClk has no effect on cardClk. From the release on, cardClk follows extClk, and clkCfg shows the clock register.
- R8: ioPullUp and c8 stay 0 until c4 is high and pgood is seen. After that, ioPullUp is 1 and c8 equals activation bit 4, tracking later writes.
- R9: ioLink is 1 only after completion and only while supply bit 5 is 1.
- R10: On completion, statSync is set and intN goes low. Writing 1 to status bit 1 clears the flag and releases intN, while the card lines stay up. Writing 0 there leaves the flag set.
- R11: cardRst is 0 until completion. From completion on, it equals activation bit 2.
- R12: If pgood is absent for `PGOOD_TIMEOUT_US` ticks (default 50) after the C4 release, all card lines go low, statErr is set and the block is idle. Writing 1 to status bit 0 clears statErr.
- R13: The start bit clears itself when the sequence begins, so after an abort the block stays idle without a new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register address |
| wrData | input | 8 | Register write data |
| pgood | input | 1 | Card supply stable |
| extClk | input | 1 | Card clock from the clock generator |
| vccEn | output | 1 | Card supply enable |
| vccSel | output | 2 | Card supply level |
| cardRst | output | 1 | Card reset line |
| cardClk | output | 1 | Card clock line |
| c4 | output | 1 | C4 contact |
| c8 | output | 1 | C8 contact |
| ioPullUp | output | 1 | I/O pull-up to card supply |
| ioLink | output | 1 | Card I/O to host I/O switch enable |
| intN | output | 1 | Active-low interrupt |
| statSync | output | 1 | Completion flag |
| statErr | output | 1 | Power-good timeout flag |
| clkCfg | output | 8 | Clock register contents for the clock generator |

## Verification
Assertions check on every cycle how the phases may follow one another. The machine leaves idle only on the full start condition. The pulse is entered only from the supply ramp, and each timed phase ends only when the counter is zero. C4 rises only on an expired count, the I/O pull-up rises only after C4 is up, completion sets the done flag, an abort sets the error flag with the supply already off, and the start bit is clear whenever the supply turns on. Only the bench scenarios can show the exact tick counts of each phase and that only one pulse occurs. They also show that extClk is ignored before the release, that the write-1-to-clear flags respond to the right bits, and that the block stays idle after an abort.

// File: rtl/card_sync_pkg.sv
`timescale 1ns/1ps
package card_sync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_PULSE,
    ST_C4WAIT,
    ST_PGWAIT,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    DLY_SUPPLY,
    DLY_PULSE,
    DLY_C4,
    DLY_PGOOD
  } dlySel_t;

  typedef struct packed {
    logic    load;
    dlySel_t dly;
    logic    takeStart;
    logic    markDone;
    logic    markErr;
    logic    supplyOn;
    logic    pulseOn;
    logic    c4Up;
    logic    linesUp;
  } seqStrobe_t;

endpackage

// File: rtl/card_sync_ctrl.sv
`timescale 1ns/1ps
module card_sync_ctrl
  import card_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cntZero,
  input  logic       pgood,
  output seqStrobe_t strobe
);

  seqState_t state, nextState;
  seqStrobe_t s;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    s = '0;
    s.dly = DLY_SUPPLY;
    unique case (state)
      ST_IDLE: if (startReq) begin
        nextState   = ST_RAMP;
        s.load      = 1'b1;
        s.dly       = DLY_SUPPLY;
        s.takeStart = 1'b1;
      end
      ST_RAMP: if (cntZero) begin
        nextState = ST_PULSE;
        s.load    = 1'b1;
        s.dly     = DLY_PULSE;
      end
      ST_PULSE: if (cntZero) begin
        nextState = ST_C4WAIT;
        s.load    = 1'b1;
        s.dly     = DLY_C4;
      end
      ST_C4WAIT: if (cntZero) begin
        nextState = ST_PGWAIT;
        s.load    = 1'b1;
        s.dly     = DLY_PGOOD;
      end
      ST_PGWAIT: begin
        if (pgood) begin
          nextState  = ST_DONE;
          s.markDone = 1'b1;
        end else if (cntZero) begin
          nextState = ST_IDLE;
          s.markErr = 1'b1;
        end
      end
      ST_DONE: nextState = ST_DONE;
      default: nextState = ST_IDLE;
    endcase
    s.supplyOn = (state != ST_IDLE);
    s.pulseOn  = (state == ST_PULSE);
    s.c4Up     = (state == ST_PGWAIT) || (state == ST_DONE);
    s.linesUp  = (state == ST_DONE);
  end

  assign strobe = s;

  // R1: leaving idle requires the full start condition
  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_IDLE && state == ST_RAMP) |-> $past(startReq));

  // R4: the ramp ends only on an expired count
  assert_ramp_ends_on_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RAMP && state != ST_RAMP) |-> $past(cntZero));

  // R5: the single pulse is only entered from the ramp
  assert_pulse_from_ramp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && $past(state) != ST_PULSE) |-> $past(state) == ST_RAMP);

endmodule

// File: rtl/card_sync_path.sv
`timescale 1ns/1ps
module card_sync_path
  import card_sync_pkg::*;
#(
  parameter int ADDR_W           = 2,
  parameter int ACT_ADDR         = 0,
  parameter int SUP_ADDR         = 1,
  parameter int CLK_ADDR         = 2,
  parameter int STAT_ADDR        = 3,
  parameter int VCC_TO_CLK_US    = 20,
  parameter int CLK_HI_US        = 9,
  parameter int CLK_TO_C4_US     = 18,
  parameter int PGOOD_TIMEOUT_US = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              extClk,
  input  seqStrobe_t        strobe,
  output logic              startReq,
  output logic              cntZero,
  output logic              vccEn,
  output logic [1:0]        vccSel,
  output logic              cardRst,
  output logic              cardClk,
  output logic              c4,
  output logic              c8,
  output logic              ioPullUp,
  output logic              ioLink,
  output logic              intN,
  output logic              statSync,
  output logic              statErr,
  output logic [7:0]        clkCfg
);

  localparam int MAX_A   = (VCC_TO_CLK_US > CLK_HI_US) ? VCC_TO_CLK_US : CLK_HI_US;
  localparam int MAX_B   = (CLK_TO_C4_US > PGOOD_TIMEOUT_US) ? CLK_TO_C4_US : PGOOD_TIMEOUT_US;
  localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(ACT_ADDR);
  localparam logic [ADDR_W-1:0] A_SUP  = ADDR_W'(SUP_ADDR);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(CLK_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  initial begin
    assert (VCC_TO_CLK_US >= 1 && CLK_HI_US >= 1 && CLK_TO_C4_US >= 1 && PGOOD_TIMEOUT_US >= 1)
      else $error("delays must be at least one tick");
  end

  logic [CNT_W-1:0] cnt, dlyValue;
  logic startBit, typeBit, cardBit, c8Bit, rstBit, ioEnBit;
  logic [1:0] vccLevel;
  logic [7:0] clkReg;
  logic syncFlag, errFlag;

  always_comb begin
    unique case (strobe.dly)
      DLY_SUPPLY: dlyValue = CNT_W'(VCC_TO_CLK_US);
      DLY_PULSE:  dlyValue = CNT_W'(CLK_HI_US);
      DLY_C4:     dlyValue = CNT_W'(CLK_TO_C4_US);
      default:    dlyValue = CNT_W'(PGOOD_TIMEOUT_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     cnt <= '0;
    else if (strobe.load)          cnt <= dlyValue;
    else if (usTick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit <= 1'b0; typeBit <= 1'b0; cardBit <= 1'b0;
      c8Bit    <= 1'b0; rstBit  <= 1'b0; ioEnBit <= 1'b0;
      vccLevel <= '0;   clkReg  <= '0;
      syncFlag <= 1'b0; errFlag <= 1'b0;
    end else begin
      if (strobe.takeStart) startBit <= 1'b0;
      if (wrEn) begin
        if (wrAddr == A_ACT) begin
          typeBit <= wrData[6];
          cardBit <= wrData[7];
          c8Bit   <= wrData[4];
          rstBit  <= wrData[2];
          if (!strobe.supplyOn && !strobe.takeStart) startBit <= wrData[0];
        end
        if (wrAddr == A_SUP) begin
          vccLevel <= wrData[7:6];
          ioEnBit  <= wrData[5];
        end
        if (wrAddr == A_CLK) clkReg <= wrData;
        if (wrAddr == A_STAT) begin
          if (wrData[1]) syncFlag <= 1'b0;
          if (wrData[0]) errFlag  <= 1'b0;
        end
      end
      if (strobe.markDone) syncFlag <= 1'b1;
      if (strobe.markErr)  errFlag  <= 1'b1;
    end
  end

  assign startReq = startBit & typeBit & cardBit;
  assign vccEn    = strobe.supplyOn;
  assign vccSel   = strobe.supplyOn ? vccLevel : 2'b00;
  assign cardClk  = strobe.pulseOn | (strobe.c4Up & extClk);
  assign c4       = strobe.c4Up;
  assign ioPullUp = strobe.linesUp;
  assign c8       = strobe.linesUp & c8Bit;
  assign ioLink   = strobe.linesUp & ioEnBit;
  assign cardRst  = strobe.linesUp & rstBit;
  assign intN     = ~syncFlag;
  assign statSync = syncFlag;
  assign statErr  = errFlag;
  assign clkCfg   = clkReg;

  // R6: C4 is released only when the post-pulse count has expired
  assert_c4_on_expiry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.c4Up) |-> $past(cntZero));

  // R8: the pull-up never comes up before C4 is released
  assert_pullup_after_c4_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioPullUp) |-> $past(c4));

  // R10: completion always carries the done flag
  assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.linesUp) |-> syncFlag);

  // R12: an error flag only appears with the supply already dropped
  assert_abort_supply_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !vccEn);

  // R13: the start bit is consumed when the supply turns on
  assert_start_consumed_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vccEn) |-> !startBit);

endmodule

// File: rtl/card_sync_activate.sv
`timescale 1ns/1ps
module card_sync_activate
  import card_sync_pkg::*;
#(
  parameter int ADDR_W           = 2,
  parameter int ACT_ADDR         = 0,
  parameter int SUP_ADDR         = 1,
  parameter int CLK_ADDR         = 2,
  parameter int STAT_ADDR        = 3,
  parameter int VCC_TO_CLK_US    = 20,
  parameter int CLK_HI_US        = 9,
  parameter int CLK_TO_C4_US     = 18,
  parameter int PGOOD_TIMEOUT_US = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              pgood,
  input  logic              extClk,
  output logic              vccEn,
  output logic [1:0]        vccSel,
  output logic              cardRst,
  output logic              cardClk,
  output logic              c4,
  output logic              c8,
  output logic              ioPullUp,
  output logic              ioLink,
  output logic              intN,
  output logic              statSync,
  output logic              statErr,
  output logic [7:0]        clkCfg
);

  seqStrobe_t strobe;
  logic startReq, cntZero;

  card_sync_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cntZero  (cntZero),
    .pgood    (pgood),
    .strobe   (strobe)
  );

  card_sync_path #(
    .ADDR_W           (ADDR_W),
    .ACT_ADDR         (ACT_ADDR),
    .SUP_ADDR         (SUP_ADDR),
    .CLK_ADDR         (CLK_ADDR),
    .STAT_ADDR        (STAT_ADDR),
    .VCC_TO_CLK_US    (VCC_TO_CLK_US),
    .CLK_HI_US        (CLK_HI_US),
    .CLK_TO_C4_US     (CLK_TO_C4_US),
    .PGOOD_TIMEOUT_US (PGOOD_TIMEOUT_US)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .extClk   (extClk),
    .strobe   (strobe),
    .startReq (startReq),
    .cntZero  (cntZero),
    .vccEn    (vccEn),
    .vccSel   (vccSel),
    .cardRst  (cardRst),
    .cardClk  (cardClk),
    .c4       (c4),
    .c8       (c8),
    .ioPullUp (ioPullUp),
    .ioLink   (ioLink),
    .intN     (intN),
    .statSync (statSync),
    .statErr  (statErr),
    .clkCfg   (clkCfg)
  );

endmodule

// File: tb/card_sync_activate_bench.sv
`timescale 1ns/1ps
module card_sync_activate_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic pgood = 1'b0;
  logic extClk = 1'b0;
  logic vccEn, cardRst, cardClk, c4, c8, ioPullUp, ioLink, intN, statSync, statErr;
  logic [1:0] vccSel;
  logic [7:0] clkCfg;

  int nChecks = 0;
  int nFails = 0;
  int rampTicks, hiTicks, c4Ticks, pulses;
  logic earlyLines, selBad;

  always #2 clk = ~clk;

  card_sync_activate u_card_sync_activate (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pgood(pgood), .extClk(extClk), .vccEn(vccEn),
    .vccSel(vccSel), .cardRst(cardRst), .cardClk(cardClk), .c4(c4), .c8(c8),
    .ioPullUp(ioPullUp), .ioLink(ioLink), .intN(intN), .statSync(statSync),
    .statErr(statErr), .clkCfg(clkCfg)
  );

  // one-cycle tick every third clock
  initial begin
    forever begin
      repeat (2) begin @(posedge clk); #1 usTick = 1'b0; end
      @(posedge clk); #1 usTick = 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; pgood = 1'b0; extClk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  function automatic int lineBits();
    return {vccEn, vccSel, cardRst, cardClk, c4, c8, ioPullUp, ioLink};
  endfunction

  // counts ticks per phase until C4 rises
  task automatic measure(input logic [1:0] expSel);
    logic prevClk = 1'b0;
    rampTicks = 0; hiTicks = 0; c4Ticks = 0; pulses = 0;
    earlyLines = 1'b0; selBad = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (c4) break;
      if (cardClk && !prevClk) pulses++;
      prevClk = cardClk;
      if (ioPullUp || c8 || ioLink || cardRst || !intN) earlyLines = 1'b1;
      if (vccEn && vccSel != expSel) selBad = 1'b1;
      if (vccEn && usTick) begin
        if (cardClk)          hiTicks++;
        else if (pulses == 0) rampTicks++;
        else                  c4Ticks++;
      end
    end
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!intN) break;
    end
  endtask

  task automatic t_reset();
    doReset();
    @(negedge clk);
    check("R2 lines idle", lineBits(), 0);
    check("R2 intN high", intN, 1);
    check("R2 flags clear", {statSync, statErr}, 0);
  endtask

  task automatic t_noStart();
    wr(2'd1, 8'hC0);
    wr(2'd0, 8'h41);
    repeat (30) @(negedge clk);
    check("R1 no card bit", lineBits(), 0);
    wr(2'd0, 8'h81);
    repeat (30) @(negedge clk);
    check("R1 no type bit", lineBits(), 0);
    wr(2'd0, 8'hC0);
    repeat (30) @(negedge clk);
    check("R1 no start bit", lineBits(), 0);
  endtask

  task automatic t_fullSeq();
    doReset();
    wr(2'd1, 8'hA0);
    wr(2'd0, 8'hD5);
    measure(2'd2);
    check("R3 vccSel during sequence", selBad, 0);
    check("R3 supply on", vccEn, 1);
    check("R4 ramp ticks", rampTicks, 20);
    check("R5 pulse ticks", hiTicks, 9);
    check("R5 pulse count", pulses, 1);
    check("R6 post-pulse ticks", c4Ticks, 18);
    check("R6 c4 released", c4, 1);
    check("R8 lines before pgood", earlyLines, 0);
    repeat (5) @(negedge clk);
    check("R8 no pullup without pgood", ioPullUp, 0);
    check("R11 reset held before done", cardRst, 0);
    pgood = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 pullup", ioPullUp, 1);
    check("R8 c8 from bit4", c8, 1);
    check("R9 link enabled", ioLink, 1);
    check("R10 done flag", statSync, 1);
    check("R10 intN low", intN, 0);
    check("R11 reset from bit2", cardRst, 1);
    wr(2'd2, 8'h5A);
    check("R7 clkCfg", clkCfg, 8'h5A);
    extClk = 1'b1; #1;
    check("R7 follows extClk high", cardClk, 1);
    @(negedge clk); extClk = 1'b0; #1;
    check("R7 follows extClk low", cardClk, 0);
    wr(2'd3, 8'h01);
    check("R10 wrong bit keeps flag", statSync, 1);
    wr(2'd3, 8'h02);
    check("R10 W1C clears", statSync, 0);
    check("R10 intN released", intN, 1);
    check("R10 lines stay", {vccEn, c4, ioPullUp}, 3'b111);
    wr(2'd0, 8'h00);
    check("R8 c8 tracks bit4", c8, 0);
    check("R11 reset tracks bit2", cardRst, 0);
  endtask

  task automatic t_noIoEn();
    doReset();
    pgood = 1'b1; extClk = 1'b1;
    wr(2'd1, 8'h40);
    wr(2'd0, 8'hC1);
    measure(2'd1);
    check("R7 extClk ignored before release", pulses, 1);
    check("R7 pulse width unchanged", hiTicks, 9);
    check("R3 vccSel level 1", selBad, 0);
    check("R7 clock handed over", cardClk, 1);
    waitDone();
    check("R10 done", statSync, 1);
    check("R9 link disabled", ioLink, 0);
    check("R8 c8 low for bit4=0", c8, 0);
  endtask

  task automatic t_timeout();
    doReset();
    wr(2'd1, 8'hC0);
    wr(2'd0, 8'hC1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (statErr) break;
    end
    check("R12 error flag", statErr, 1);
    check("R12 lines dropped", lineBits(), 0);
    check("R12 no done", {statSync, intN}, 1);
    repeat (300) @(negedge clk);
    check("R13 stays idle", vccEn, 0);
    wr(2'd3, 8'h01);
    check("R12 W1C clears", statErr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_noStart();
    t_fullSeq();
    t_noIoEn();
    t_timeout();
    summary();
    $finish;
  end

endmodule